// File: doc/BRIEF.md
# Asynchronous Serial Controller Host Register Interface

This block is the processor-facing front end of an asynchronous serial controller. A host reaches it through a chip select, a single address line, read and write strobes, and an 8-bit data bus. Address 0 is the data port, which holds the transmit holding register on writes and the received character on reads. Address 1 is the control/status port.

The control port has one address but carries two kinds of word. After reset, the first write to it is the mode word, which sets baud factor, character length, parity and stop bits. Every later write is a command word, which sets the transmitter and receiver enables, break and the modem-control lines. A command with bit 6 set performs an internal reset, and the port then expects a mode word again. Reads of the control port return status.

The transmit shifter, receive shifter and baud generation sit outside this block. They use the exported configuration fields, the holding-register handshake and the receive-data-read strobe.

Top module: `serial_ctrl_regif`

## Requirements
- R1: With `cs` low, a strobe on `wr` or `rd` changes no state and does not pulse `rx_read`. With `cs` high, `addr`=0 selects the data port and `addr`=1 selects the control/status port.
- R2: After reset, the first control-port write is the mode word. Its fields are bits 1:0 `baud_fac`, bits 3:2 `char_len`, bit 4 `par_en`, bit 5 `par_even` and bits 7:6 `stop_sel`. Later control writes leave it unchanged.
- R3: Every control write after the mode word is a command. Bit 0 drives `tx_en` and bit 2 drives `rx_en`. Bit 3 drives `tx_break`. When bit 1 is set, `dtr_n` goes to 0, and when bit 5 is set, `rts_n` goes to 0.
- R4: A command with bit 6 set clears the mode fields and all command outputs, empties the holding register and clears the receive buffer, RxRDY and the error flags. The next control write is then taken as a mode word.
- R5: After reset, status reads 0x05 when `tx_idle`=1 and `dsr_n`=1. All mode fields, `tx_en`, `rx_en` and `tx_break` are 0, and `dtr_n` and `rts_n` are 1.
- R6: Status bits, from bit 0 upward, are TxRDY, RxRDY, TxEMPTY, parity error, overrun, framing error, a constant 0 and DSR. TxRDY is the inverse of `tx_full`.
- R7: A data-port read returns the received character and clears RxRDY. It also raises `rx_read` for the strobe cycle.
- R8: A `rx_valid` pulse while `rx_en`=1 loads `rx_char` and sets RxRDY. While `rx_en`=0 the pulse is ignored.
- R9: A character accepted while RxRDY=1, with no data read in the same cycle, sets overrun. An accepted character with `rx_perr` or `rx_ferr` set raises the parity or framing flag. All three flags are sticky.
- R10: A command with bit 4 set clears the parity, overrun and framing flags.
- R11: The status DSR bit is the inverse of `dsr_n` after a two-flop synchronizer. A fall of `dsr_n` shows in status after two rising edges.
- R12: A data-port write while TxRDY=1 loads `tx_data` and sets `tx_full`. A `tx_take` pulse empties the register. TxEMPTY is 1 only when the register is empty and `tx_idle`=1.
- R13: A data-port write while `tx_full`=1 is ignored, and `tx_data` keeps the character already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| addr | input | 1 | 0 selects the data port, 1 selects control/status |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: the receive buffer or the status selected by addr |
| rx_read | output | 1 | Pulses during a data-port read |
| rx_valid | input | 1 | Pulses when the receiver has a new character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error for the character on rx_char |
| rx_ferr | input | 1 | Framing error for the character on rx_char |
| tx_data | output | 8 | Character in the transmit holding register |
| tx_full | output | 1 | The transmit holding register is occupied |
| tx_take | input | 1 | The transmitter has taken the held character |
| tx_idle | input | 1 | The transmit shifter is empty |
| dsr_n | input | 1 | Asynchronous data-set-ready, active low |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_break | output | 1 | Forces the serial output low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| baud_fac | output | 2 | Baud factor field of the mode word |
| char_len | output | 2 | Character length field |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| stop_sel | output | 2 | Stop-bit field |

## Verification
The in-line assertions check on every cycle that:
- a second control write never alters the mode word;
- an internal-reset command leaves the sequencer waiting for a mode word with everything cleared;
- a data read drops RxRDY;
- an accepted character arriving on a full buffer raises overrun;
- an error-reset clears the flags;
- a data write to an occupied holding register leaves it unchanged.

Only the bench's scenarios show the rest. These are the exact status byte layout, the two-edge delay of the DSR synchronizer, the gating by chip select, and a receive pulse being ignored while the receiver is disabled. They also include the full sequence of mode, commands, internal reset and a fresh mode word.

// File: rtl/serial_regif_pkg.sv
// Shared widths, the mode-word layout and the bit positions of command and
// status, used by every part of the serial controller register interface.
package serial_regif_pkg;
    localparam int DW = 8;

    // Mode word, packed from bit 7 down to bit 0.
    typedef struct packed {
        logic [1:0] stop;
        logic       even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] baud;
    } mode_t;

    // Command bit positions.
    localparam int CB_TXEN = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RXEN = 2;
    localparam int CB_BRK  = 3;
    localparam int CB_ERST = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IRST = 6;

    // Status bit positions.
    localparam int SB_TXRDY = 0;
    localparam int SB_RXRDY = 1;
    localparam int SB_TXEMP = 2;
    localparam int SB_PE    = 3;
    localparam int SB_OE    = 4;
    localparam int SB_FE    = 5;
    localparam int SB_ZERO  = 6;
    localparam int SB_DSR   = 7;
endpackage

// File: rtl/regif_decode.sv
// Turns chip select, address and strobes into per-port access pulses.
// Assumes rd and wr are single-cycle strobes and are never high together.
module regif_decode (
    input  logic cs,
    input  logic addr,
    input  logic rd,
    input  logic wr,
    output logic data_wr,
    output logic data_rd,
    output logic ctl_wr
);
    // Qualify each strobe with chip select and the port address.
    always_comb begin
        data_wr = cs && wr && !addr;
        data_rd = cs && rd && !addr;
        ctl_wr  = cs && wr &&  addr;
    end
endmodule

// File: rtl/regif_ctl_seq.sv
// Mode/command sequencer for the shared control address. It holds the mode
// word and the persistent command bits. It also produces single-cycle pulses
// for the internal reset and the error reset. Assumes ctl_wr is a
// single-cycle pulse.
module regif_ctl_seq
    import serial_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output mode_t         mode_q,
    output logic          tx_en,
    output logic          rx_en,
    output logic          brk,
    output logic          dtr,
    output logic          rts,
    output logic          soft_rst,
    output logic          err_clr
);
    logic expect_mode;
    logic cmd_wr;

    // Command write and its single-cycle side effects.
    always_comb begin
        cmd_wr   = ctl_wr && !expect_mode;
        soft_rst = cmd_wr && wdata[CB_IRST];
        err_clr  = cmd_wr && wdata[CB_ERST];
    end

    // Sequence the shared address: first write is mode, then commands.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            expect_mode <= 1'b1;
            mode_q      <= '0;
            tx_en       <= 1'b0;
            rx_en       <= 1'b0;
            brk         <= 1'b0;
            dtr         <= 1'b0;
            rts         <= 1'b0;
        end else if (ctl_wr && expect_mode) begin
            mode_q      <= mode_t'(wdata);
            expect_mode <= 1'b0;
        end else if (cmd_wr) begin
            tx_en <= wdata[CB_TXEN];
            rx_en <= wdata[CB_RXEN];
            brk   <= wdata[CB_BRK];
            dtr   <= wdata[CB_DTR];
            rts   <= wdata[CB_RTS];
        end
    end

    // R2: a command write without internal reset keeps the mode word.
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wdata[CB_IRST]) |=> $stable(mode_q));

    // R4: an internal reset leaves everything cleared and awaiting a mode word.
    a_r4_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (expect_mode && mode_q == '0 && !tx_en && !rx_en
                      && !brk && !dtr && !rts));
endmodule

// File: rtl/regif_txhold.sv
// Transmit holding register. It accepts a character only while empty and
// frees itself when the transmitter takes the character. Assumes tx_take is
// raised only while the register is full.
module regif_txhold
    import serial_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tx_take,
    output logic [DW-1:0] hold_q,
    output logic          full_q
);
    // Load when empty, release on take, and ignore writes while full.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (data_wr && !full_q) begin
            hold_q <= wdata;
            full_q <= 1'b1;
        end else if (tx_take) begin
            full_q <= 1'b0;
        end
    end

    // R13: a write into an occupied register leaves the character intact.
    a_r13_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && data_wr && !soft_rst) |=> $stable(hold_q));

    // R12: a take empties the register.
    a_r12_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && tx_take) |=> !full_q);
endmodule

// File: rtl/regif_rxstat.sv
// Receive buffer with its ready flag and the sticky parity, overrun and
// framing flags. Assumes rx_valid is a single-cycle pulse with its error
// qualifiers valid in the same cycle.
module regif_rxstat
    import serial_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          rx_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    input  logic          data_rd,
    input  logic          err_clr,
    output logic [DW-1:0] buf_q,
    output logic          rdy_q,
    output logic          pe_q,
    output logic          oe_q,
    output logic          fe_q
);
    logic rx_load;

    // A character is accepted only while the receiver is enabled.
    always_comb rx_load = rx_valid && rx_en;

    // Update the buffer, ready flag and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            buf_q <= '0;
            rdy_q <= 1'b0;
            pe_q  <= 1'b0;
            oe_q  <= 1'b0;
            fe_q  <= 1'b0;
        end else begin
            if (rx_load)
                buf_q <= rx_char;
            rdy_q <= rx_load ? 1'b1 : (data_rd ? 1'b0 : rdy_q);
            pe_q  <= (err_clr ? 1'b0 : pe_q) | (rx_load && rx_perr);
            fe_q  <= (err_clr ? 1'b0 : fe_q) | (rx_load && rx_ferr);
            oe_q  <= (err_clr ? 1'b0 : oe_q) | (rx_load && rdy_q && !data_rd);
        end
    end

    // R7: a data read with no new character drops the ready flag.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_load) |=> !rdy_q);

    // R9: a character arriving on a full, unread buffer raises overrun.
    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rdy_q && !data_rd && !soft_rst) |=> oe_q);

    // R10: an error reset with no new character clears all three flags.
    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_load) |=> (!pe_q && !oe_q && !fe_q));
endmodule

// File: rtl/regif_sync.sv
// Multi-flop synchronizer for one asynchronous level. It resets to RST_VAL.
// Assumes STAGES is at least 2.
module regif_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    always_comb q = chain[STAGES-1];
endmodule

// File: rtl/serial_ctrl_regif.sv
// Host-side register interface of an asynchronous serial controller.
// It decodes data and control/status ports and sequences mode and command
// words. It holds the transmit character and the receive status, and drives
// the enables and active-low modem lines. Assumes single-cycle rd/wr strobes.
module serial_ctrl_regif
    import serial_regif_pkg::*;
#(
    parameter int DSR_SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rx_read,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    output logic [DW-1:0] tx_data,
    output logic          tx_full,
    input  logic          tx_take,
    input  logic          tx_idle,
    input  logic          dsr_n,
    output logic          tx_en,
    output logic          rx_en,
    output logic          tx_break,
    output logic          dtr_n,
    output logic          rts_n,
    output logic [1:0]    baud_fac,
    output logic [1:0]    char_len,
    output logic          par_en,
    output logic          par_even,
    output logic [1:0]    stop_sel
);
    logic          data_wr, data_rd, ctl_wr;
    logic          soft_rst, err_clr;
    logic          dtr, rts;
    mode_t         mode_q;
    logic [DW-1:0] rx_buf;
    logic          rx_rdy, pe, oe, fe;
    logic          dsr_n_s;
    logic [DW-1:0] status;

    regif_decode u_dec (
        .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .data_wr(data_wr), .data_rd(data_rd), .ctl_wr(ctl_wr)
    );

    regif_ctl_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
        .mode_q(mode_q), .tx_en(tx_en), .rx_en(rx_en), .brk(tx_break),
        .dtr(dtr), .rts(rts), .soft_rst(soft_rst), .err_clr(err_clr)
    );

    regif_txhold u_tx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .data_wr(data_wr),
        .wdata(wdata), .tx_take(tx_take), .hold_q(tx_data), .full_q(tx_full)
    );

    regif_rxstat u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_en(rx_en),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .data_rd(data_rd), .err_clr(err_clr),
        .buf_q(rx_buf), .rdy_q(rx_rdy), .pe_q(pe), .oe_q(oe), .fe_q(fe)
    );

    regif_sync #(.STAGES(DSR_SYNC_STAGES), .RST_VAL(1'b1)) u_dsr (
        .clk(clk), .rst_n(rst_n), .d(dsr_n), .q(dsr_n_s)
    );

    // Assemble status, select read data and export configuration.
    always_comb begin
        status           = '0;
        status[SB_TXRDY] = !tx_full;
        status[SB_RXRDY] = rx_rdy;
        status[SB_TXEMP] = !tx_full && tx_idle;
        status[SB_PE]    = pe;
        status[SB_OE]    = oe;
        status[SB_FE]    = fe;
        status[SB_ZERO]  = 1'b0;
        status[SB_DSR]   = !dsr_n_s;
        rdata            = addr ? status : rx_buf;
        rx_read          = data_rd;
        dtr_n            = !dtr;
        rts_n            = !rts;
        baud_fac         = mode_q.baud;
        char_len         = mode_q.len;
        par_en           = mode_q.par_en;
        par_even         = mode_q.even;
        stop_sel         = mode_q.stop;
    end
endmodule

// File: tb/tb_serial_ctrl_regif.sv
module tb_serial_ctrl_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, addr = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_read;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic [7:0] rx_char = '0;
    logic [7:0] tx_data;
    logic       tx_full;
    logic       tx_take = 1'b0, tx_idle = 1'b1, dsr_n = 1'b1;
    logic       tx_en, rx_en, tx_break, dtr_n, rts_n, par_en, par_even;
    logic [1:0] baud_fac, char_len, stop_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got;
    logic       strobe;

    always #2 clk = ~clk;

    serial_ctrl_regif dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rx_read(rx_read), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .tx_data(tx_data), .tx_full(tx_full), .tx_take(tx_take),
        .tx_idle(tx_idle), .dsr_n(dsr_n), .tx_en(tx_en), .rx_en(rx_en),
        .tx_break(tx_break), .dtr_n(dtr_n), .rts_n(rts_n),
        .baud_fac(baud_fac), .char_len(char_len), .par_en(par_en),
        .par_even(par_even), .stop_sel(stop_sel)
    );

    // Observed views: mode fields in mode-word order, and command outputs.
    wire [7:0] mode_obs = {stop_sel, par_even, par_en, char_len, baud_fac};
    wire [7:0] cmd_obs  = {3'b000, rts_n, dtr_n, tx_break, rx_en, tx_en};

    // Vector: [23:22] op (0 write, 1 read rdata, 2 observe mode/cmd by addr,
    // 3 observe tx_data), [21] addr, [20:16] requirement, [15:8] data,
    // [7:0] expected.
    localparam int NV = 18;
    localparam logic [23:0] VECS [0:NV-1] = '{
        {2'd1, 1'b1, 5'd5,  8'h00, 8'h05},  // R5 status after reset
        {2'd2, 1'b0, 5'd5,  8'h00, 8'h00},  // R5 mode fields zero
        {2'd2, 1'b1, 5'd5,  8'h00, 8'h18},  // R5 modem lines high
        {2'd0, 1'b1, 5'd2,  8'h4E, 8'h00},  // R2 mode word
        {2'd2, 1'b0, 5'd2,  8'h00, 8'h4E},
        {2'd0, 1'b1, 5'd3,  8'h27, 8'h00},  // R3 tx, dtr, rx, rts
        {2'd2, 1'b1, 5'd3,  8'h00, 8'h03},
        {2'd2, 1'b0, 5'd2,  8'h00, 8'h4E},  // R2 mode untouched
        {2'd0, 1'b1, 5'd3,  8'h08, 8'h00},  // R3 break only
        {2'd2, 1'b1, 5'd3,  8'h00, 8'h1C},
        {2'd0, 1'b1, 5'd3,  8'h27, 8'h00},
        {2'd1, 1'b1, 5'd6,  8'h00, 8'h05},  // R6 layout
        {2'd0, 1'b0, 5'd12, 8'h41, 8'h00},  // R12 load holding
        {2'd1, 1'b1, 5'd12, 8'h00, 8'h00},
        {2'd3, 1'b0, 5'd12, 8'h00, 8'h41},
        {2'd0, 1'b0, 5'd13, 8'h55, 8'h00},  // R13 write while full
        {2'd3, 1'b0, 5'd13, 8'h00, 8'h41},
        {2'd1, 1'b1, 5'd13, 8'h00, 8'h00}
    };

    task automatic chk(input int req, input logic [7:0] g, input logic [7:0] e,
                       input string what);
        n_chk++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, g, e);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        #1;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d, output logic s);
        @(negedge clk);
        cs = 1'b1; addr = a; rd = 1'b1;
        #1;
        d = rdata; s = rx_read;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        #1;
    endtask

    task automatic rx_push(input logic [7:0] c, input logic p, input logic f);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c; rx_perr = p; rx_ferr = f;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
        #1;
    endtask

    task automatic status_is(input int req, input logic [7:0] e, input string w);
        bus_rd(1'b1, got, strobe);
        chk(req, got, e, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VECS[i];
            case (v[23:22])
                2'd0: bus_wr(v[21], v[15:8]);
                2'd1: begin
                    bus_rd(v[21], got, strobe);
                    chk(int'(v[20:16]), got, v[7:0], "read port");
                end
                2'd2: chk(int'(v[20:16]), v[21] ? cmd_obs : mode_obs, v[7:0],
                          "config outputs");
                default: chk(int'(v[20:16]), tx_data, v[7:0], "tx_data");
            endcase
        end

        // R12: take frees the register; TxEMPTY follows tx_idle.
        chk(12, {7'd0, tx_full}, 8'h01, "tx_full set");
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0; #1;
        chk(12, {7'd0, tx_full}, 8'h00, "tx_full after take");
        status_is(12, 8'h05, "status after take");
        tx_idle = 1'b0;
        status_is(12, 8'h01, "TxEMPTY with busy shifter");
        tx_idle = 1'b1;

        // R8 and R7: receive, read back, ready clears, strobe pulses.
        rx_push(8'h3C, 1'b0, 1'b0);
        status_is(8, 8'h07, "RxRDY after receive");
        bus_rd(1'b0, got, strobe);
        chk(7, got, 8'h3C, "data read");
        chk(7, {7'd0, strobe}, 8'h01, "rx_read strobe");
        status_is(7, 8'h05, "RxRDY after read");

        // R9: overrun, then parity and framing.
        rx_push(8'h11, 1'b0, 1'b0);
        rx_push(8'h22, 1'b0, 1'b0);
        status_is(9, 8'h17, "overrun status");
        bus_rd(1'b0, got, strobe);
        chk(9, got, 8'h22, "newest char kept");
        rx_push(8'h33, 1'b1, 1'b1);
        status_is(9, 8'h3F, "parity and framing set");
        bus_rd(1'b0, got, strobe);
        status_is(9, 8'h3D, "flags sticky after read");

        // R10: error reset command.
        bus_wr(1'b1, 8'h37);
        status_is(10, 8'h05, "flags cleared");
        chk(10, cmd_obs, 8'h03, "controls kept on error reset");

        // R1: accesses without chip select.
        @(negedge clk); addr = 1'b1; wr = 1'b1; wdata = 8'h40;
        @(negedge clk); wr = 1'b0; #1;
        chk(1, cmd_obs, 8'h03, "unselected control write");
        chk(1, mode_obs, 8'h4E, "unselected write keeps mode");
        rx_push(8'h66, 1'b0, 1'b0);
        @(negedge clk); addr = 1'b0; rd = 1'b1; #1;
        chk(1, {7'd0, rx_read}, 8'h00, "unselected read strobe");
        @(negedge clk); rd = 1'b0; #1;
        status_is(1, 8'h07, "RxRDY kept after unselected read");
        bus_rd(1'b0, got, strobe);
        chk(1, got, 8'h66, "selected data read");

        // R8: receiver disabled ignores rx_valid.
        bus_wr(1'b1, 8'h23);
        rx_push(8'h44, 1'b0, 1'b0);
        status_is(8, 8'h05, "disabled receiver status");
        bus_rd(1'b0, got, strobe);
        chk(8, got, 8'h66, "buffer unchanged when disabled");

        // R11: DSR synchronizer takes two edges.
        @(negedge clk); dsr_n = 1'b0; addr = 1'b1;
        @(negedge clk); #1;
        chk(11, {7'd0, rdata[7]}, 8'h00, "DSR after one edge");
        @(negedge clk); #1;
        chk(11, {7'd0, rdata[7]}, 8'h01, "DSR after two edges");

        // R4: internal reset and a fresh mode word.
        bus_wr(1'b0, 8'h77);
        bus_wr(1'b1, 8'h40);
        chk(4, mode_obs, 8'h00, "mode cleared");
        chk(4, cmd_obs, 8'h18, "controls cleared");
        chk(4, {7'd0, tx_full}, 8'h00, "holding emptied");
        status_is(4, 8'h85, "status after internal reset");
        bus_rd(1'b0, got, strobe);
        chk(4, got, 8'h00, "receive buffer cleared");
        bus_wr(1'b1, 8'h4F);
        chk(4, mode_obs, 8'h4F, "next write is mode");
        bus_wr(1'b1, 8'h01);
        chk(4, cmd_obs, 8'h19, "then command");
        chk(4, mode_obs, 8'h4F, "mode kept");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule